// File: doc/BRIEF.md
# Serial Result Output Port

This block sits behind a data converter and hands each 14-bit conversion result to a host over a single serial data line. When the converter reports that a conversion has finished, the result is captured into a 16-bit frame register with two zero bits appended below the least significant result bit. The host then clocks the frame out most significant bit first. Each falling edge of the shift clock advances the line to the next bit, so a receiver can capture on the rising edge. Fourteen shift-clock cycles carry the whole result. Sixteen is the usual word length, and every clock past the frame yields logic 0.

The shift clock may be the converter's own clock output looped back, or a host clock that runs on its own. Both reach the block as an ordinary input and are sampled in the system clock domain, where a synchronizer and a falling-edge detector turn them into one-cycle shift strobes. Two active-low qualifiers gate the transfer: a read enable and a chip select. Either one held high freezes the frame and floats the line. This lets a host window an exactly counted burst out of a free-running shift clock. The three-state pin is modelled as a data bit plus an output enable, and the data bit is driven to 0 while the enable is low.

Top module: `sro_serial_port`

## Requirements
- R1: While reset is asserted and directly after it, the output enable and the data bit are 0, and the frame register holds all zeros.
- R2: A one-cycle conversion-done pulse loads the frame as the 14 result bits in bits 15..2 and zeros in bits 1..0. With both qualifiers low, the line then shows result bit 13.
- R3: Each falling edge of the shift clock, taken while both qualifiers are low, moves the line to the next lower frame bit. Rising edges leave the line unchanged.
- R4: After 16 qualified falling edges since the last load, the line shows 0 for every further edge.
- R5: While the read enable is high, the output enable and data bit are 0, and falling edges do not move the frame position.
- R6: While the chip select is high, the output enable and data bit are 0, and falling edges do not move the frame position.
- R7: When a conversion-done pulse and a qualified falling edge fall in the same cycle, the load wins. The line shows bit 13 of the new result, and the next edge shows its bit 12.
- R8: The output enable is 1 exactly when both qualifiers are low, one system clock after they settle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a new result is valid |
| result | input | 14 | Conversion result, captured on conv_done |
| sclk_in | input | 1 | Shift clock, looped-back or external, asynchronous |
| read_en_n | input | 1 | Active-low read qualifier; high freezes and floats |
| chip_sel_n | input | 1 | Active-low chip select; high freezes and floats |
| ser_dout | output | 1 | Serial data bit, 0 while not enabled |
| ser_oe | output | 1 | Output enable modelling the three-state driver |

## Verification
The two events that can share a cycle are a new result being captured and a shift strobe advancing the frame. The bench provokes this collision by timing the conversion-done pulse so that it lands in the cycle in which the synchronized falling edge fires. It judges the outcome by the line showing the new result's top bit, followed one edge later by its second bit. If the old frame had shifted instead, the line would show zeros. Random runs mix loads, inhibit windows and edge counts beyond 16 against a bench model of the frame position.

// File: rtl/sro_pkg.sv
package sro_pkg;
   // Choice of output stage for the serial pin model
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/sro_sclk_fall.sv
module sro_sclk_fall #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_in,
   output logic fall
);
   logic cur;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cur = sclk_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[0] <= 1'b0;
                  else        stg_q[0] <= sclk_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[i] <= 1'b0;
                  else        stg_q[i] <= stg_q[i-1];
               end
            end
         end
         assign cur = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign fall = prev_q & ~cur;

   // R3
   fall_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/sro_frame_shift.sv
module sro_frame_shift #(
   parameter int unsigned RES_W   = 14,
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RES_W-1:0]   result,
   input  logic               shift,
   output logic [FRAME_W-1:0] q
);
   localparam int unsigned PAD = FRAME_W - RES_W;

   logic [FRAME_W-1:0] load_val;

   always_comb load_val = (FRAME_W)'(result) << PAD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[FRAME_W-2:0], 1'b0};
   end

   generate
      if (PAD > 0) begin : g_pad_chk
         // R2
         pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (q[PAD-1:0] == '0));
      end
   endgenerate

   // R4
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> !q[0]);
endmodule

// File: rtl/sro_out_gate.sv
module sro_out_gate #(
   parameter sro_pkg::out_mode_e OUT_MODE = sro_pkg::OUT_REG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic read_en_n,
   input  logic chip_sel_n,
   output logic dout,
   output logic oe
);
   logic en;
   assign en = ~read_en_n & ~chip_sel_n;

   generate
      if (OUT_MODE == sro_pkg::OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               oe   <= 1'b0;
               dout <= 1'b0;
            end else begin
               oe   <= en;
               dout <= en & bit_in;
            end
         end
         // R8
         float_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (read_en_n || chip_sel_n) |=> (!oe && !dout));
      end else begin : g_comb
         assign oe   = en;
         assign dout = en & bit_in;
         // R8
         float_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (read_en_n || chip_sel_n) |-> (!oe && !dout));
      end
   endgenerate
endmodule

// File: rtl/sro_serial_port.sv
module sro_serial_port #(
   parameter int unsigned        RES_W       = 14,
   parameter int unsigned        FRAME_W     = 16,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter sro_pkg::out_mode_e OUT_MODE    = sro_pkg::OUT_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done,
   input  logic [RES_W-1:0] result,
   input  logic             sclk_in,
   input  logic             read_en_n,
   input  logic             chip_sel_n,
   output logic             ser_dout,
   output logic             ser_oe
);
   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

   generate
      if (RES_W < 1 || FRAME_W < RES_W || FRAME_W < 2) begin : g_bad_width
         $error("sro_serial_port: frame must be at least 2 bits and hold the result");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("sro_serial_port: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic               fall;
   logic               shift;
   logic [FRAME_W-1:0] frame_q;

   sro_sclk_fall #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_in (sclk_in),
      .fall    (fall)
   );

   assign shift = fall & ~read_en_n & ~chip_sel_n;

   sro_frame_shift #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (conv_done),
      .result (result),
      .shift  (shift),
      .q      (frame_q)
   );

   sro_out_gate #(.OUT_MODE(OUT_MODE)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (frame_q[FRAME_W-1]),
      .read_en_n  (read_en_n),
      .chip_sel_n (chip_sel_n),
      .dout       (ser_dout),
      .oe         (ser_oe)
   );

   // Checker state: qualified shifts since the last load, saturating
   logic [CNT_W-1:0] shifts_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shifts_q <= CNT_W'(FRAME_W);
      else if (conv_done)
         shifts_q <= '0;
      else if (shift && shifts_q != CNT_W'(FRAME_W))
         shifts_q <= shifts_q + 1'b1;
   end

   // R4
   drained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shifts_q == CNT_W'(FRAME_W)) |-> (frame_q == '0));

   // R5
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_done && read_en_n) |=> $stable(frame_q));

   // R6
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_done && chip_sel_n) |=> $stable(frame_q));

   // R7
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> (frame_q[FRAME_W-1] == $past(result[RES_W-1])));
endmodule

// File: tb/tb_sro_serial_port.sv
`timescale 1ns/1ps
module tb_sro_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [13:0] result = '0;
   logic        sclk_in = 1'b1;
   logic        read_en_n = 1'b1;
   logic        chip_sel_n = 1'b1;
   logic        ser_dout;
   logic        ser_oe;

   int checks = 0;
   int errors = 0;

   logic [15:0] exp_frame = '0;
   int          exp_idx = 16;

   always #2.5 clk = ~clk;

   sro_serial_port dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_done  (conv_done),
      .result     (result),
      .sclk_in    (sclk_in),
      .read_en_n  (read_en_n),
      .chip_sel_n (chip_sel_n),
      .ser_dout   (ser_dout),
      .ser_oe     (ser_oe)
   );

   function automatic logic [15:0] frame_of(logic [13:0] r);
      return {r, 2'b00};
   endfunction

   function automatic logic exp_bit(logic [15:0] f, int idx);
      return (idx < 16) ? f[15-idx] : 1'b0;
   endfunction

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {oe,dout} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic check_line(string req);
      logic en;
      en = !read_en_n && !chip_sel_n;
      check(req, {ser_oe, ser_dout}, {en, en & exp_bit(exp_frame, exp_idx)});
   endtask

   task automatic do_load(logic [13:0] r);
      result    = r;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      exp_frame = frame_of(r);
      exp_idx   = 0;
      repeat (3) @(negedge clk);
   endtask

   // One shift-clock period: rise, check, fall, check
   task automatic sclk_cycle(logic rd_n, logic cs_n);
      string req;
      read_en_n  = rd_n;
      chip_sel_n = cs_n;
      sclk_in    = 1'b1;
      repeat (4) @(negedge clk);
      check_line("R3 rising edge no effect");
      sclk_in = 1'b0;
      repeat (4) @(negedge clk);
      if (!rd_n && !cs_n && exp_idx < 16) exp_idx++;
      if (rd_n)           req = "R5 read inhibit";
      else if (cs_n)      req = "R6 select inhibit";
      else if (exp_idx >= 16) req = "R4 zero tail";
      else                req = "R3 shift";
      check_line(req);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      check("R1 in reset", {ser_oe, ser_dout}, 2'b00);
      rst_n = 1'b1;
      read_en_n  = 1'b0;
      chip_sel_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 after reset", {ser_oe, ser_dout}, 2'b10);
      check("R8 enable both low", {ser_oe, 1'b0}, 2'b10);

      // R2 / R3 directed: full 16-bit frame
      do_load(14'h2D3B);
      check_line("R2 load shows top bit");
      for (int i = 0; i < 18; i++) sclk_cycle(1'b0, 1'b0);

      // R5 / R6 directed: inhibit mid-frame, position held
      do_load(14'h1A5C);
      sclk_cycle(1'b0, 1'b0);
      sclk_cycle(1'b1, 1'b0);
      sclk_cycle(1'b0, 1'b1);
      sclk_cycle(1'b1, 1'b1);
      sclk_cycle(1'b0, 1'b0);
      check_line("R5 R6 position kept");

      // R7 collision: load and qualified falling edge in one cycle
      do_load(14'h0000);
      sclk_cycle(1'b0, 1'b0);
      sclk_cycle(1'b0, 1'b0);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
      sclk_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      result    = 14'h2C01;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      exp_frame = frame_of(14'h2C01);
      exp_idx   = 0;
      repeat (3) @(negedge clk);
      check("R7 load wins top bit", {ser_oe, ser_dout}, 2'b11);
      sclk_cycle(1'b0, 1'b0);
      check("R7 next bit of new result", {ser_oe, ser_dout}, 2'b10);

      // Random mix
      for (int t = 0; t < 25; t++) begin
         int n;
         do_load(14'($urandom));
         check_line("R2 random load");
         n = $urandom_range(0, 22);
         for (int k = 0; k < n; k++) begin
            logic rd, cs;
            rd = ($urandom_range(0, 3) == 0);
            cs = ($urandom_range(0, 4) == 0);
            sclk_cycle(rd, cs);
         end
      end

      // R8: enable returns when both qualifiers fall
      read_en_n  = 1'b1;
      chip_sel_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 read high floats", {ser_oe, ser_dout}, 2'b00);
      read_en_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 both low enables", {ser_oe, 1'b0}, 2'b10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule